// File: doc/BRIEF.md
# Strided Two-Dimensional Local-Memory DMA

This engine copies rectangular blocks of bytes between a byte-addressed main DRAM and a banked on-chip local memory. The local memory has two 4 KiB banks, one for instructions and one for data. Software first sets a local address and a DRAM address. It then writes a packed length word to one of two start selects. One select moves data from DRAM into local memory. The other moves data from local memory out to DRAM.

The length word holds three fields: a row length, rounded up to a multiple of eight bytes; a row count; and a skip. Inside a row, both addresses step by one byte per byte moved. At the end of each row the DRAM address also jumps forward by the skip. The local address simply keeps running, wrapping inside its own bank. The engine moves at most one byte per clock. It raises `busy` for the length of a transfer and pulses `done` once at the end.

The DRAM side uses valid/ready. The request channel (`dram_req_*`) carries both reads and writes. Once the engine raises `dram_req_valid`, it holds the address, direction and write data steady until `dram_req_ready` is seen high. The engine never drops a pending request. Read data comes back in request order on a second channel (`dram_rd_*`). The engine keeps `dram_rd_ready` high for the whole of a DRAM-to-local transfer, so it never back-pressures that channel.

The local memory port is a plain synchronous SRAM port. A read returns data in the cycle after `lm_en` is high with `lm_we` low. The memory must hold that data while `lm_en` stays low. The engine relies on this hold when a DRAM write stalls.

Top module: `lmem_dma`

## Requirements
- R1: The row length in bytes is the field `cfg_wdata[11:0]` with its low three bits forced to 1, plus one. It is therefore a multiple of 8, from 8 to 4096.
- R2: The row count is `cfg_wdata[19:12]` + 1. A transfer moves exactly row count × row length bytes.
- R3: The DRAM address rises by one for each byte inside a row. After the last byte of each row it rises by one more plus the skip `cfg_wdata[31:20]`. It wraps modulo 2^24.
- R4: The local address rises by one for each byte and wraps within 12 bits. Bit 12 of the local address register sets the bank on `lm_bank`: 1 is instruction memory and 0 is data memory. The bank does not change during a transfer.
- R5: A write with `cfg_sel`=2 starts a DRAM-to-local copy, made of DRAM reads (`dram_req_we`=0) and local writes. A write with `cfg_sel`=3 starts a local-to-DRAM copy, made of local reads and DRAM writes (`dram_req_we`=1).
- R6: `cfg_sel`=0 loads the local address from `cfg_wdata[12:0]`. `cfg_sel`=1 loads the DRAM address from `cfg_wdata[23:0]` and drops the upper bits. Both registers keep their values after a transfer, and every transfer starts from them.
- R7: After reset, `busy`, `done`, `dram_req_valid`, `dram_rd_ready` and `lm_en` are low. `busy` is high from the cycle after the start write. `done` is high for exactly one cycle, the cycle after the last byte completes, and `busy` is low in that cycle.
- R8: Any configuration write made while `busy` is high is ignored. It changes no register and starts nothing.
- R9: While `dram_req_valid` is high and `dram_req_ready` is low, the valid, address and direction are held in the next cycle. With ready always high and read data returned one cycle after acceptance, an N-byte transfer keeps `busy` high for N+1 cycles. Stalls on either channel do not change the bytes moved.
- R10: `dram_rd_ready` is high only while a DRAM-to-local transfer is busy. It is never high together with a pending DRAM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 local address, 1 DRAM address, 2 start DRAM-to-local, 3 start local-to-DRAM |
| cfg_wdata | input | 32 | Configuration data or packed length word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| dram_req_valid | output | 1 | DRAM request valid |
| dram_req_ready | input | 1 | DRAM request accepted |
| dram_req_we | output | 1 | 1 write, 0 read |
| dram_req_addr | output | 24 | DRAM byte address |
| dram_req_wdata | output | 8 | DRAM write byte |
| dram_rd_valid | input | 1 | DRAM read data valid |
| dram_rd_ready | output | 1 | Engine accepts read data |
| dram_rd_data | input | 8 | DRAM read byte |
| lm_en | output | 1 | Local memory access enable |
| lm_we | output | 1 | Local memory write |
| lm_bank | output | 1 | 1 instruction bank, 0 data bank |
| lm_addr | output | 12 | Local byte address within the bank |
| lm_wdata | output | 8 | Local write byte |
| lm_rdata | input | 8 | Local read byte, one cycle after a read, held while idle |

## Verification
With zero-wait memories, the first DRAM request or local read comes in the cycle after the start write. The last byte completes N cycles later, and `done` follows one cycle after that. The bench therefore samples on falling edges, counts the `busy` cycles, and expects N+1. It expects `done` with `busy` low at the next falling edge, and `done` low one cycle after that. The bench memory models record every accepted DRAM request and update local memory at the edge where the handshake happens. After `done`, the bench compares these records with address, data and direction sequences computed from the length fields. Stalled runs are checked only on content and order, never on cycle counts.

// File: rtl/lmdma_pkg.sv
package lmdma_pkg;
  typedef enum logic [1:0] {
    SEL_LOCAL    = 2'd0,
    SEL_DRAM     = 2'd1,
    SEL_TO_LOCAL = 2'd2,
    SEL_TO_DRAM  = 2'd3
  } cfg_sel_e;

  typedef enum logic {
    DIR_TO_LOCAL = 1'b0,
    DIR_TO_DRAM  = 1'b1
  } dir_e;
endpackage

// File: rtl/lmdma_len_decode.sv
module lmdma_len_decode #(
  parameter int LEN_W = 12,
  parameter int CNT_W = 8,
  parameter int SKIP_W = 12,
  parameter int ALIGN_BITS = 3,
  localparam int CFG_W = LEN_W + CNT_W + SKIP_W,
  localparam int TOT_W = LEN_W + CNT_W + 2
) (
  input  logic [CFG_W-1:0]  len_word,
  output logic [LEN_W:0]    row_len,
  output logic [SKIP_W-1:0] skip,
  output logic [TOT_W-1:0]  total
);
  localparam logic [LEN_W-1:0] ALIGN_MASK = LEN_W'((1 << ALIGN_BITS) - 1);

  logic [LEN_W-1:0] fld_len;
  logic [CNT_W-1:0] fld_cnt;
  logic [CNT_W:0]   rows;

  always_comb begin
    fld_len = len_word[LEN_W-1:0];
    fld_cnt = len_word[LEN_W +: CNT_W];
    skip    = len_word[LEN_W+CNT_W +: SKIP_W];
    row_len = {1'b0, fld_len | ALIGN_MASK} + 1'b1;
    rows    = {1'b0, fld_cnt} + 1'b1;
    total   = TOT_W'(row_len) * TOT_W'(rows);
  end
endmodule

// File: rtl/lmdma_dram_agu.sv
module lmdma_dram_agu #(
  parameter int DRAM_AW = 24,
  parameter int LEN_W = 12,
  parameter int SKIP_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [DRAM_AW-1:0] load_addr,
  input  logic [LEN_W:0]     load_row_len,
  input  logic [SKIP_W-1:0]  load_skip,
  input  logic               step,
  output logic [DRAM_AW-1:0] addr
);
  logic [DRAM_AW-1:0] addr_q;
  logic [LEN_W:0]     col_q;
  logic [LEN_W:0]     row_len_q;
  logic [SKIP_W-1:0]  skip_q;
  logic               row_end;

  assign row_end = (col_q == row_len_q - 1'b1);
  assign addr    = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      col_q     <= '0;
      row_len_q <= '0;
      skip_q    <= '0;
    end else if (load) begin
      addr_q    <= load_addr;
      col_q     <= '0;
      row_len_q <= load_row_len;
      skip_q    <= load_skip;
    end else if (step) begin
      if (row_end) begin
        col_q  <= '0;
        addr_q <= addr_q + DRAM_AW'(1) + DRAM_AW'(skip_q);
      end else begin
        col_q  <= col_q + 1'b1;
        addr_q <= addr_q + DRAM_AW'(1);
      end
    end
  end
endmodule

// File: rtl/lmdma_local_agu.sv
module lmdma_local_agu #(
  parameter int LM_AW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LM_AW:0]   load_addr,
  input  logic             step,
  output logic [LM_AW-1:0] ptr,
  output logic             bank
);
  logic [LM_AW-1:0] ptr_q;
  logic             bank_q;

  assign ptr  = ptr_q;
  assign bank = bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      bank_q <= 1'b0;
    end else if (load) begin
      ptr_q  <= load_addr[LM_AW-1:0];
      bank_q <= load_addr[LM_AW];
    end else if (step) begin
      ptr_q  <= ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/lmdma_ctrl.sv
module lmdma_ctrl
  import lmdma_pkg::*;
#(
  parameter int TOT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  dir_e             start_dir,
  input  logic [TOT_W-1:0] total,
  input  logic             dram_req_ready,
  input  logic             dram_rd_valid,
  output logic             busy,
  output logic             done,
  output logic             dram_req_valid,
  output logic             dram_req_we,
  output logic             dram_rd_ready,
  output logic             lm_en,
  output logic             lm_we,
  output logic             dram_step,
  output logic             local_step
);
  logic             busy_q, done_q, rd_pend_q;
  dir_e             dir_q;
  logic [TOT_W-1:0] issue_left_q, cpl_left_q;
  logic             to_dram, req_hs, rd_hs, fetch, cpl, issue, last;

  always_comb begin
    to_dram        = (dir_q == DIR_TO_DRAM);
    dram_req_valid = busy_q && (to_dram ? rd_pend_q : (issue_left_q != '0));
    dram_req_we    = busy_q && to_dram;
    req_hs         = dram_req_valid && dram_req_ready;
    dram_rd_ready  = busy_q && !to_dram;
    rd_hs          = dram_rd_ready && dram_rd_valid;
    fetch          = busy_q && to_dram && (issue_left_q != '0) && (!rd_pend_q || dram_req_ready);
    cpl            = to_dram ? req_hs : rd_hs;
    issue          = to_dram ? fetch : req_hs;
    last           = cpl && (cpl_left_q == TOT_W'(1));
    lm_en          = fetch || rd_hs;
    lm_we          = rd_hs;
    dram_step      = req_hs;
    local_step     = fetch || rd_hs;
  end

  assign busy = busy_q;
  assign done = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      done_q       <= 1'b0;
      rd_pend_q    <= 1'b0;
      dir_q        <= DIR_TO_LOCAL;
      issue_left_q <= '0;
      cpl_left_q   <= '0;
    end else begin
      done_q <= last;
      if (start) begin
        busy_q       <= 1'b1;
        dir_q        <= start_dir;
        issue_left_q <= total;
        cpl_left_q   <= total;
        rd_pend_q    <= 1'b0;
      end else if (busy_q) begin
        if (issue) issue_left_q <= issue_left_q - 1'b1;
        if (cpl)   cpl_left_q   <= cpl_left_q - 1'b1;
        if (to_dram) rd_pend_q <= fetch || (rd_pend_q && !req_hs);
        if (last) begin
          busy_q    <= 1'b0;
          rd_pend_q <= 1'b0;
        end
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dram_req_valid && !dram_req_ready |=> dram_req_valid && $stable(dram_req_we));
  // R10
  rd_ready_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dram_rd_ready |-> busy && !(dram_req_valid && dram_req_we));
  // R5
  lm_write_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lm_en && lm_we |-> dram_rd_valid && !dram_req_we);
endmodule

// File: rtl/lmem_dma.sv
module lmem_dma
  import lmdma_pkg::*;
#(
  parameter int DRAM_AW = 24,
  parameter int LM_AW = 12,
  parameter int LEN_W = 12,
  parameter int CNT_W = 8,
  parameter int SKIP_W = 12,
  parameter int ALIGN_BITS = 3,
  localparam int CFG_W = LEN_W + CNT_W + SKIP_W,
  localparam int TOT_W = LEN_W + CNT_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic               busy,
  output logic               done,
  output logic               dram_req_valid,
  input  logic               dram_req_ready,
  output logic               dram_req_we,
  output logic [DRAM_AW-1:0] dram_req_addr,
  output logic [7:0]         dram_req_wdata,
  input  logic               dram_rd_valid,
  output logic               dram_rd_ready,
  input  logic [7:0]         dram_rd_data,
  output logic               lm_en,
  output logic               lm_we,
  output logic               lm_bank,
  output logic [LM_AW-1:0]   lm_addr,
  output logic [7:0]         lm_wdata,
  input  logic [7:0]         lm_rdata
);
  logic [LM_AW:0]     lm_addr_q;
  logic [DRAM_AW-1:0] dram_addr_q;
  logic               cfg_ok, start;
  cfg_sel_e           sel;
  dir_e               start_dir;
  logic [LEN_W:0]     row_len;
  logic [SKIP_W-1:0]  skip;
  logic [TOT_W-1:0]   total;
  logic               dram_step, local_step;

  always_comb begin
    sel       = cfg_sel_e'(cfg_sel);
    cfg_ok    = cfg_we && !busy;
    start     = cfg_ok && (sel == SEL_TO_LOCAL || sel == SEL_TO_DRAM);
    start_dir = (sel == SEL_TO_DRAM) ? DIR_TO_DRAM : DIR_TO_LOCAL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lm_addr_q   <= '0;
      dram_addr_q <= '0;
    end else if (cfg_ok) begin
      case (sel)
        SEL_LOCAL: lm_addr_q   <= cfg_wdata[LM_AW:0];
        SEL_DRAM:  dram_addr_q <= cfg_wdata[DRAM_AW-1:0];
        default: ;
      endcase
    end
  end

  lmdma_len_decode #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .SKIP_W(SKIP_W), .ALIGN_BITS(ALIGN_BITS)
  ) u_len (
    .len_word(cfg_wdata), .row_len(row_len), .skip(skip), .total(total)
  );

  lmdma_dram_agu #(
    .DRAM_AW(DRAM_AW), .LEN_W(LEN_W), .SKIP_W(SKIP_W)
  ) u_dagu (
    .clk(clk), .rst_n(rst_n), .load(start), .load_addr(dram_addr_q),
    .load_row_len(row_len), .load_skip(skip), .step(dram_step), .addr(dram_req_addr)
  );

  lmdma_local_agu #(.LM_AW(LM_AW)) u_lagu (
    .clk(clk), .rst_n(rst_n), .load(start), .load_addr(lm_addr_q),
    .step(local_step), .ptr(lm_addr), .bank(lm_bank)
  );

  lmdma_ctrl #(.TOT_W(TOT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .start_dir(start_dir), .total(total),
    .dram_req_ready(dram_req_ready), .dram_rd_valid(dram_rd_valid),
    .busy(busy), .done(done), .dram_req_valid(dram_req_valid),
    .dram_req_we(dram_req_we), .dram_rd_ready(dram_rd_ready),
    .lm_en(lm_en), .lm_we(lm_we), .dram_step(dram_step), .local_step(local_step)
  );

  assign lm_wdata       = dram_rd_data;
  assign dram_req_wdata = lm_rdata;

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(lm_addr_q) && $stable(dram_addr_q));
  // R4
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(lm_bank));
  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dram_req_valid && !dram_req_ready |=> $stable(dram_req_addr));
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !lm_en && !dram_req_valid && !dram_rd_ready);
endmodule

// File: tb/tb_lmem_dma.sv
module tb_lmem_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        busy, done;
  logic        dram_req_valid, dram_req_we;
  logic        dram_req_ready = 1'b1;
  logic [23:0] dram_req_addr;
  logic [7:0]  dram_req_wdata;
  logic        dram_rd_valid, dram_rd_ready;
  logic [7:0]  dram_rd_data;
  logic        lm_en, lm_we, lm_bank;
  logic [11:0] lm_addr;
  logic [7:0]  lm_wdata;
  logic [7:0]  lm_rdata = '0;

  always #5 clk = ~clk;

  lmem_dma dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .busy(busy), .done(done), .dram_req_valid(dram_req_valid), .dram_req_ready(dram_req_ready),
    .dram_req_we(dram_req_we), .dram_req_addr(dram_req_addr), .dram_req_wdata(dram_req_wdata),
    .dram_rd_valid(dram_rd_valid), .dram_rd_ready(dram_rd_ready), .dram_rd_data(dram_rd_data),
    .lm_en(lm_en), .lm_we(lm_we), .lm_bank(lm_bank), .lm_addr(lm_addr),
    .lm_wdata(lm_wdata), .lm_rdata(lm_rdata)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit stall = 1'b0, rsp_gate = 1'b1;

  function automatic logic [7:0] dpat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  // memory models
  logic [7:0]  lmem [0:1][0:4095];
  logic [23:0] log_addr [0:4095];
  logic        log_we   [0:4095];
  logic [7:0]  log_data [0:4095];
  int          log_n = 0;
  logic [7:0]  rq [0:255];
  int          rq_wr = 0, rq_rd = 0;

  assign dram_rd_valid = (rq_wr != rq_rd) && rsp_gate;
  assign dram_rd_data  = rq[rq_rd % 256];

  always @(posedge clk) begin
    if (dram_req_valid && dram_req_ready) begin
      log_addr[log_n] <= dram_req_addr;
      log_we[log_n]   <= dram_req_we;
      log_data[log_n] <= dram_req_wdata;
      log_n <= log_n + 1;
      if (!dram_req_we) begin
        rq[rq_wr % 256] <= dpat(dram_req_addr);
        rq_wr <= rq_wr + 1;
      end
    end
    if (dram_rd_valid && dram_rd_ready) rq_rd <= rq_rd + 1;
    if (lm_en) begin
      if (lm_we) lmem[lm_bank][lm_addr] <= lm_wdata;
      else       lm_rdata <= lmem[lm_bank][lm_addr];
    end
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (stall) begin
      dram_req_ready = (cyc % 3) != 0;
      rsp_gate       = (cyc % 4) != 1;
    end else begin
      dram_req_ready = 1'b1;
      rsp_gate       = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_done(output int bc);
    bit seen;
    bc = 0; seen = 0;
    for (int i = 0; i < 20000; i++) begin
      if (done) begin seen = 1; break; end
      if (busy) bc++;
      @(negedge clk);
    end
    chk(seen, "R7 done never seen", 0, 1);
    chk(!busy, "R7 busy low with done", busy, 0);
    @(negedge clk);
    chk(!done, "R7 done lasts one cycle", done, 0);
  endtask

  function automatic logic [23:0] exp_d(input logic [23:0] b, input int k, input int rl, input int sk);
    return b + 24'(k) + 24'((k / rl) * sk);
  endfunction

  task automatic verify(input string tag, input int base, input int n_exp, input bit to_dram,
                        input int lb, input int la, input logic [23:0] db, input int rl, input int sk);
    int bad_a, bad_w, bad_d;
    logic [11:0] lk;
    bad_a = -1; bad_w = -1; bad_d = -1;
    chk(log_n - base == n_exp, {tag, " R2 byte count"}, log_n - base, n_exp);
    for (int k = 0; k < n_exp; k++) begin
      lk = 12'(la + k);
      if (bad_a < 0 && log_addr[base+k] !== exp_d(db, k, rl, sk)) bad_a = k;
      if (bad_w < 0 && log_we[base+k] !== to_dram) bad_w = k;
      if (to_dram) begin
        if (bad_d < 0 && log_data[base+k] !== lmem[lb][lk]) bad_d = k;
      end else begin
        if (bad_d < 0 && lmem[lb][lk] !== dpat(exp_d(db, k, rl, sk))) bad_d = k;
      end
    end
    chk(bad_a < 0, {tag, " R3 dram address sequence"},
        (bad_a < 0) ? 0 : log_addr[base+bad_a], (bad_a < 0) ? 0 : exp_d(db, bad_a, rl, sk));
    chk(bad_w < 0, {tag, " R5 direction"}, (bad_w < 0) ? 0 : log_we[base+bad_w], to_dram);
    chk(bad_d < 0, {tag, " R4 local data and address"}, bad_d, -1);
  endtask

  // R7: reset state
  task automatic t_reset;
    chk(!busy && !done, "R7 reset busy/done", {busy, done}, 0);
    chk(!dram_req_valid && !dram_rd_ready && !lm_en, "R7 reset ports quiet",
        {dram_req_valid, dram_rd_ready, lm_en}, 0);
  endtask

  // R5/R3/R9: DRAM to local, 2 rows of 8, skip 16
  task automatic t_to_local;
    int base, bc;
    base = log_n;
    cfg_write(2'd0, 32'h0000_0010);
    cfg_write(2'd1, 32'h0000_1000);
    cfg_write(2'd2, (32'd16 << 20) | (32'd1 << 12) | 32'd5);
    wait_done(bc);
    verify("to_local", base, 16, 1'b0, 0, 12'h010, 24'h001000, 8, 16);
    chk(bc == 17, "R9 zero-wait busy cycles to_local", bc, 17);
  endtask

  // R1/R5: local to DRAM from instruction bank, field 9 -> 16-byte rows, 3 rows
  task automatic t_to_dram;
    int base, bc;
    base = log_n;
    cfg_write(2'd0, 32'h0000_1200);
    cfg_write(2'd1, 32'h0000_3000);
    cfg_write(2'd3, (32'h020 << 20) | (32'd2 << 12) | 32'h009);
    wait_done(bc);
    verify("to_dram R1", base, 48, 1'b1, 1, 12'h200, 24'h003000, 16, 32);
    chk(bc == 49, "R9 zero-wait busy cycles to_dram", bc, 49);
  endtask

  // R4/R3/R6: both address wraps, bank isolation, DRAM mask
  task automatic t_wrap;
    int base, bc, bad;
    logic [7:0] keep [0:7];
    for (int i = 0; i < 8; i++) keep[i] = lmem[0][i];
    base = log_n;
    cfg_write(2'd0, 32'h0000_1FF8);
    cfg_write(2'd1, 32'hAB_FFFFF8);
    cfg_write(2'd2, 32'h0000_0008);
    wait_done(bc);
    verify("wrap R6", base, 16, 1'b0, 1, 12'hFF8, 24'hFFFFF8, 16, 0);
    bad = -1;
    for (int i = 0; i < 8; i++) if (bad < 0 && lmem[0][i] !== keep[i]) bad = i;
    chk(bad < 0, "R4 other bank untouched", bad, -1);
  endtask

  // R8/R6: writes during busy ignored, registers retained for next transfer
  task automatic t_busy_ignore;
    int base, bc;
    base = log_n;
    cfg_write(2'd0, 32'h0000_0100);
    cfg_write(2'd1, 32'h0000_2000);
    cfg_write(2'd2, (32'd1 << 12) | 32'd7);
    cfg_write(2'd1, 32'h0000_9000);
    cfg_write(2'd0, 32'h0000_0555);
    cfg_write(2'd3, 32'h0000_0000);
    wait_done(bc);
    verify("ignore R8", base, 16, 1'b0, 0, 12'h100, 24'h002000, 8, 0);
    @(negedge clk);
    chk(!busy && (log_n - base) == 16, "R8 no restart from ignored write", busy, 0);
    base = log_n;
    cfg_write(2'd3, 32'h0000_0000);
    wait_done(bc);
    verify("retain R6", base, 8, 1'b1, 0, 12'h100, 24'h002000, 8, 0);
  endtask

  // R9/R10: stalls on request and response channels
  task automatic t_stall;
    int base, bc;
    stall = 1'b1;
    base = log_n;
    cfg_write(2'd0, 32'h0000_0300);
    cfg_write(2'd1, 32'h0000_4000);
    cfg_write(2'd3, (32'd5 << 20) | (32'd2 << 12) | 32'd0);
    wait_done(bc);
    verify("stall to_dram R9", base, 24, 1'b1, 0, 12'h300, 24'h004000, 8, 5);
    base = log_n;
    cfg_write(2'd0, 32'h0000_1400);
    cfg_write(2'd1, 32'h0000_5000);
    cfg_write(2'd2, (32'd3 << 20) | (32'd2 << 12) | 32'd2);
    wait_done(bc);
    verify("stall to_local R10", base, 24, 1'b0, 1, 12'h400, 24'h005000, 8, 3);
    chk(rq_wr == rq_rd, "R10 all read data consumed", rq_wr - rq_rd, 0);
    stall = 1'b0;
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 4096; i++) lmem[b][i] = 8'(i * 7 + b * 101 + 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_to_local();
    t_to_dram();
    t_wrap();
    t_busy_ignore();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule